// File: doc/BRIEF.md
# Separable Six-Tap Luma Interpolator

This block produces a 16x16 block of quarter-sample luma prediction values from a 21x21 window of 8-bit reference pixels. The window arrives one full row per beat over a valid/ready stream, top row first. The block keeps the five most recent rows in a sliding line buffer. Once that buffer is full, each newly accepted row completes one output row.

Each output row is computed in two separable passes. The vertical pass runs first and applies a six-tap filter down six stacked rows, producing 21 signed, unscaled intermediates. The horizontal pass then applies the same taps across those intermediates to make 17 half-sample values. These are rounded, shifted and clipped back to 8 bits in a single step. Adjacent pairs of half-sample values are averaged with rounding to give the 16 quarter-sample outputs of the row.

A pulse on `start` opens a block. Output rows leave over a second valid/ready stream, and a one-cycle `done` marks the end of the block. A stall on the output holds the whole pipeline.

Top module: `sepf_luma_interp`

## Requirements
- R1: A `start` pulse while idle opens a block that accepts 21 input rows, top to bottom. Pixel column c of an input row sits at bits [8c+7:8c] of `in_row`. Output sample j sits at bits [8j+7:8j] of `out_row`.
- R2: The vertical pass for output row k forms, for each column c, v[c] = p[k][c] - 5p[k+1][c] + 20p[k+2][c] + 20p[k+3][c] - 5p[k+4][c] + p[k+5][c]. The value is kept unscaled as a signed 16-bit intermediate.
- R3: The horizontal pass forms 17 sums, h[j] = v[j] - 5v[j+1] + 20v[j+2] + 20v[j+3] - 5v[j+4] + v[j+5], for j = 0..16. Any column index above 20 is replaced by 20.
- R4: Each half-sample value is z[j] = (h[j] + 512) arithmetically shifted right by 10, then clipped to 0..255.
- R5: Output sample j is (z[j] + z[j+1] + 1) >> 1, for j = 0..15.
- R6: The first five input rows produce no output. Output row k becomes valid in the cycle after input row k+5 is accepted. Exactly 16 rows leave, in order.
- R7: While `out_valid` is high and `out_ready` is low, `out_row` stays unchanged and no further input is accepted once the buffer is primed. No row is lost or duplicated.
- R8: `done` is high for exactly one cycle, namely the cycle after the 16th output row is accepted. From that cycle on the block is idle.
- R9: A `start` pulse while a block is in progress has no effect on the rows produced or on their count.
- R10: While idle, `in_ready` and `out_valid` are low and `in_valid` is ignored.
- R11: During and right after reset, `in_ready`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a block when idle |
| in_valid | input | 1 | Input row present |
| in_ready | output | 1 | Block accepts an input row |
| in_row | input | 168 | 21 reference pixels of one row |
| out_valid | output | 1 | Output row present |
| out_ready | input | 1 | Consumer accepts the output row |
| out_row | output | 128 | 16 quarter-sample results of one row |
| done | output | 1 | One-cycle end-of-block pulse |

## Verification
Draining the output register and reloading it with the next row can happen on the same edge. In that cycle an output row is taken and, in the same cycle, a new input row is accepted. The bench provokes this by holding `out_ready` high while rows stream in, and mixes in stall patterns that alternate with it. Every taken row is compared against an integer model of the two filter passes, so a row that was dropped or taken twice shows up as a mismatch or as a wrong row count.

// File: rtl/sepf_pkg.sv
package sepf_pkg;
   localparam int TAP_N = 6;
   localparam int LEAD  = TAP_N - 1;

   // symmetric six-tap kernel
   function automatic int tap_coef(input int idx);
      case (idx)
         0, 5:    return 1;
         1, 4:    return -5;
         default: return 20;
      endcase
   endfunction
endpackage

// File: rtl/sepf_tap6.sv
module sepf_tap6
   import sepf_pkg::*;
#(
   parameter int IN_W      = 8,
   parameter bit IN_SIGNED = 1'b0,
   parameter int OUT_W     = 16
) (
   input  logic [TAP_N*IN_W-1:0]   samples,
   output logic signed [OUT_W-1:0] result
);
   if (OUT_W <= IN_W) begin : g_bad_width
      $error("sepf_tap6: OUT_W must exceed IN_W");
   end

   logic signed [OUT_W-1:0] ext  [TAP_N];
   logic signed [OUT_W-1:0] prod [TAP_N];

   for (genvar i = 0; i < TAP_N; i++) begin : g_tap
      localparam logic signed [OUT_W-1:0] COEF = OUT_W'(tap_coef(i));
      if (IN_SIGNED) begin : g_sext
         assign ext[i] = OUT_W'($signed(samples[i*IN_W +: IN_W]));
      end else begin : g_zext
         assign ext[i] = OUT_W'({1'b0, samples[i*IN_W +: IN_W]});
      end
      assign prod[i] = ext[i] * COEF;
   end

   always_comb begin
      result = '0;
      for (int i = 0; i < TAP_N; i++) begin
         result = result + prod[i];
      end
   end
endmodule

// File: rtl/sepf_vpass.sv
module sepf_vpass
   import sepf_pkg::*;
#(
   parameter int COLS  = 21,
   parameter int PIX_W = 8,
   parameter int MID_W = 16
) (
   input  logic [TAP_N*COLS*PIX_W-1:0] rows_in,
   output logic [COLS*MID_W-1:0]       mid_out
);
   localparam int ROW_W = COLS * PIX_W;

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [TAP_N*PIX_W-1:0] column;
      logic signed [MID_W-1:0] vsum;
      for (genvar t = 0; t < TAP_N; t++) begin : g_row
         assign column[t*PIX_W +: PIX_W] = rows_in[t*ROW_W + c*PIX_W +: PIX_W];
      end
      sepf_tap6 #(.IN_W(PIX_W), .IN_SIGNED(1'b0), .OUT_W(MID_W)) u_tap (
         .samples(column),
         .result (vsum)
      );
      assign mid_out[c*MID_W +: MID_W] = vsum;
   end
endmodule

// File: rtl/sepf_hpass.sv
module sepf_hpass
   import sepf_pkg::*;
#(
   parameter int COLS   = 21,
   parameter int HALF_N = 17,
   parameter int MID_W  = 16,
   parameter int ACC_W  = 24,
   parameter int PIX_W  = 8,
   parameter int SHIFT  = 10
) (
   input  logic [COLS*MID_W-1:0]    mid_in,
   output logic [HALF_N*PIX_W-1:0]  half_out
);
   localparam logic signed [ACC_W-1:0] RND  = ACC_W'(2 ** (SHIFT - 1));
   localparam logic signed [ACC_W-1:0] PMAX = ACC_W'(2 ** PIX_W - 1);

   for (genvar j = 0; j < HALF_N; j++) begin : g_pos
      logic [TAP_N*MID_W-1:0]  win;
      logic signed [ACC_W-1:0] acc;
      logic signed [ACC_W-1:0] scaled;
      logic [PIX_W-1:0]        pix;
      for (genvar t = 0; t < TAP_N; t++) begin : g_src
         // columns past the right edge repeat the last one
         localparam int SRC = (j + t > COLS - 1) ? COLS - 1 : j + t;
         assign win[t*MID_W +: MID_W] = mid_in[SRC*MID_W +: MID_W];
      end
      sepf_tap6 #(.IN_W(MID_W), .IN_SIGNED(1'b1), .OUT_W(ACC_W)) u_tap (
         .samples(win),
         .result (acc)
      );
      assign scaled = (acc + RND) >>> SHIFT;
      always_comb begin
         if (scaled < 0)          pix = '0;
         else if (scaled > PMAX)  pix = '1;
         else                     pix = scaled[PIX_W-1:0];
      end
      assign half_out[j*PIX_W +: PIX_W] = pix;
   end
endmodule

// File: rtl/sepf_qavg.sv
module sepf_qavg #(
   parameter int N     = 16,
   parameter int PIX_W = 8
) (
   input  logic [(N+1)*PIX_W-1:0] half_in,
   output logic [N*PIX_W-1:0]     q_out
);
   for (genvar j = 0; j < N; j++) begin : g_avg
      assign q_out[j*PIX_W +: PIX_W] =
         PIX_W'(({1'b0, half_in[j*PIX_W +: PIX_W]} +
                 {1'b0, half_in[(j+1)*PIX_W +: PIX_W]} +
                 (PIX_W+1)'(1)) >> 1);
   end
endmodule

// File: rtl/sepf_luma_interp.sv
module sepf_luma_interp
   import sepf_pkg::*;
#(
   parameter int BLK   = 16,
   parameter int PIX_W = 8,
   parameter int MID_W = 16,
   parameter int ACC_W = 24,
   parameter int SHIFT = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic [(BLK+5)*PIX_W-1:0]   in_row,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [BLK*PIX_W-1:0]       out_row,
   output logic                       done
);
   localparam int WIN    = BLK + LEAD;
   localparam int HALF_N = BLK + 1;
   localparam int ROW_W  = WIN * PIX_W;
   localparam int OUT_W  = BLK * PIX_W;
   localparam int IN_CW  = $clog2(WIN + 1);
   localparam int OUT_CW = $clog2(BLK + 1);

   if (MID_W < PIX_W + 7) begin : g_chk_mid
      $error("sepf_luma_interp: MID_W too narrow for vertical sums");
   end
   if (ACC_W < MID_W + 6) begin : g_chk_acc
      $error("sepf_luma_interp: ACC_W too narrow for horizontal sums");
   end
   if (SHIFT < 1 || SHIFT >= ACC_W) begin : g_chk_shift
      $error("sepf_luma_interp: SHIFT out of range");
   end

   logic                  busy_q;
   logic [IN_CW-1:0]      in_cnt;
   logic [OUT_CW-1:0]     out_cnt;
   logic                  out_vld_q;
   logic                  done_q;
   logic [OUT_W-1:0]      out_q;
   logic [ROW_W-1:0]      hold_q [LEAD];
   logic                  primed;
   logic                  in_fire;
   logic                  out_fire;
   logic [TAP_N*ROW_W-1:0] vwin;
   logic [WIN*MID_W-1:0]  mid;
   logic [HALF_N*PIX_W-1:0] half;
   logic [OUT_W-1:0]      q_row;

   assign primed   = in_cnt >= IN_CW'(LEAD);
   assign in_ready = busy_q && (in_cnt < IN_CW'(WIN)) &&
                     (!primed || !out_vld_q || out_ready);
   assign in_fire  = in_valid && in_ready;
   assign out_fire = out_vld_q && out_ready;

   // six-row window: oldest buffered row at slot 0, arriving row on top
   for (genvar t = 0; t < LEAD; t++) begin : g_win
      assign vwin[t*ROW_W +: ROW_W] = hold_q[t];
   end
   assign vwin[LEAD*ROW_W +: ROW_W] = in_row;

   sepf_vpass #(.COLS(WIN), .PIX_W(PIX_W), .MID_W(MID_W)) u_vpass (
      .rows_in(vwin),
      .mid_out(mid)
   );

   sepf_hpass #(.COLS(WIN), .HALF_N(HALF_N), .MID_W(MID_W), .ACC_W(ACC_W),
                .PIX_W(PIX_W), .SHIFT(SHIFT)) u_hpass (
      .mid_in  (mid),
      .half_out(half)
   );

   sepf_qavg #(.N(BLK), .PIX_W(PIX_W)) u_qavg (
      .half_in(half),
      .q_out  (q_row)
   );

   always_ff @(posedge clk) begin
      if (in_fire) begin
         for (int i = 0; i < LEAD - 1; i++) begin
            hold_q[i] <= hold_q[i+1];
         end
         hold_q[LEAD-1] <= in_row;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         in_cnt    <= '0;
         out_cnt   <= '0;
         out_vld_q <= 1'b0;
         done_q    <= 1'b0;
         out_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q  <= 1'b1;
               in_cnt  <= '0;
               out_cnt <= '0;
            end
         end else begin
            if (in_fire) in_cnt <= in_cnt + 1'b1;
            if (out_fire) begin
               out_cnt <= out_cnt + 1'b1;
               if (out_cnt == OUT_CW'(BLK - 1)) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end
         end
         if (in_fire && primed) begin
            out_vld_q <= 1'b1;
            out_q     <= q_row;
         end else if (out_fire) begin
            out_vld_q <= 1'b0;
         end
      end
   end

   assign out_valid = out_vld_q;
   assign out_row   = out_q;
   assign done      = done_q;
endmodule

// File: rtl/sepf_luma_interp_chk.sv
module sepf_luma_interp_chk #(
   parameter int BLK   = 16,
   parameter int PIX_W = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   start,
   input logic                   in_ready,
   input logic                   out_valid,
   input logic                   out_ready,
   input logic [BLK*PIX_W-1:0]   out_row,
   input logic                   done,
   input logic                   busy_q
);
   localparam int CW = $clog2(BLK + 1);
   logic [CW-1:0] rows_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rows_seen <= '0;
      else if (start && !busy_q) rows_seen <= '0;
      else if (out_valid && out_ready) rows_seen <= rows_seen + 1'b1;
   end

   // R7
   hold_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_row));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy_q && !out_valid && !in_ready);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !in_ready && !out_valid);

   // R9
   busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !(out_valid && out_ready) |=> busy_q);

   // R6
   row_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready |-> rows_seen < CW'(BLK));
endmodule

bind sepf_luma_interp sepf_luma_interp_chk #(.BLK(BLK), .PIX_W(PIX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_row  (out_row),
   .done     (done),
   .busy_q   (busy_q)
);

// File: tb/sim_sepf_luma_interp.sv
module sim_sepf_luma_interp;
   localparam int CLK_T = 10;
   localparam int BLK   = 16;
   localparam int WIN   = BLK + 5;
   localparam int IW    = WIN * 8;
   localparam int OW    = BLK * 8;
   localparam int NVEC  = 6;
   // pattern, seed, stall mode, extra start while busy
   localparam int TBL [NVEC][4] = '{
      '{0,  0, 0, 0},
      '{1,  0, 1, 0},
      '{2, 11, 0, 0},
      '{2, 97, 2, 1},
      '{3,  0, 3, 0},
      '{4,  5, 1, 0}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic          in_valid;
   logic          in_ready;
   logic [IW-1:0] in_row;
   logic          out_valid;
   logic          out_ready;
   logic [OW-1:0] out_row;
   logic          done;

   int checks   = 0;
   int failures = 0;

   sepf_luma_interp u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
      .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
      .done(done)
   );

   always #(CLK_T/2) clk = ~clk;

   task automatic check(input bit ok, input string tag,
                        input logic [OW-1:0] act, input logic [OW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int coef(input int t);
      if (t == 0 || t == 5) return 1;
      if (t == 1 || t == 4) return -5;
      return 20;
   endfunction

   function automatic int pix(input int pat, input int seed, input int r, input int c);
      int h;
      case (pat)
         0: return 0;
         1: return 255;
         2: begin
            h = (r * 21 + c) * 1103515245 + seed * 12345 + 7;
            return (h >>> 16) & 255;
         end
         3: return ((r + c) % 2 == 1) ? 255 : 0;
         default: return (r * 12 + c * 7 + seed) % 256;
      endcase
   endfunction

   function automatic logic [IW-1:0] make_row(input int pat, input int seed, input int r);
      logic [IW-1:0] row;
      for (int c = 0; c < WIN; c++) row[8*c +: 8] = 8'(pix(pat, seed, r, c));
      return row;
   endfunction

   // integer model of R2..R5
   function automatic logic [OW-1:0] exp_row(input int pat, input int seed, input int k);
      int v [WIN];
      int z [BLK+1];
      int h;
      logic [OW-1:0] res;
      for (int c = 0; c < WIN; c++) begin
         v[c] = 0;
         for (int t = 0; t < 6; t++) v[c] += coef(t) * pix(pat, seed, k + t, c);
      end
      for (int j = 0; j <= BLK; j++) begin
         h = 0;
         for (int t = 0; t < 6; t++) h += coef(t) * v[(j + t > WIN - 1) ? WIN - 1 : j + t];
         h = (h + 512) >>> 10;
         z[j] = (h < 0) ? 0 : (h > 255) ? 255 : h;
      end
      for (int j = 0; j < BLK; j++) res[8*j +: 8] = 8'((z[j] + z[j+1] + 1) >> 1);
      return res;
   endfunction

   function automatic bit rdy(input int mode, input int cyc);
      case (mode)
         0: return 1'b1;
         1: return (cyc % 2) == 1;
         2: return (cyc % 5) >= 2;
         default: return (cyc % 7) != 3;
      endcase
   endfunction

   task automatic run_block(input int pat, input int seed, input int stall, input int xstart);
      int r_in = 0;
      int r_out = 0;
      int cyc = 0;
      int last_out = -10;
      int dones = 0;
      bit held = 1'b0;
      bit seen = 1'b0;
      logic [OW-1:0] held_row = '0;
      while (dones == 0 && cyc < 600) begin
         start     = (cyc == 0) || (xstart != 0 && (cyc == 7 || cyc == 20));
         in_valid  = r_in < WIN;
         in_row    = make_row(pat, seed, (r_in < WIN) ? r_in : 0);
         out_ready = rdy(stall, cyc);
         #(CLK_T/4);
         if (held) check(out_valid && out_row == held_row, "R7 held row", out_row, held_row);
         held     = out_valid && !out_ready;
         held_row = out_row;
         if (out_valid && !seen) begin
            seen = 1'b1;
            check(r_in == 6, "R6 first output after six rows", OW'(r_in), OW'(6));
         end
         if (out_valid && out_ready) begin
            // R1 R2 R3 R4 R5 sample values and packing
            check(r_out < BLK && out_row == exp_row(pat, seed, r_out),
                  $sformatf("R2 R3 R4 R5 pattern %0d row %0d", pat, r_out),
                  out_row, exp_row(pat, seed, r_out));
            r_out++;
            last_out = cyc;
         end
         if (in_valid && in_ready) r_in++;
         if (done) begin
            dones++;
            check(last_out == cyc - 1 && r_out == BLK, "R8 done timing",
                  OW'(r_out), OW'(BLK));
         end
         @(negedge clk);
         cyc++;
      end
      if (dones == 0) check(1'b0, "R8 watchdog no done", OW'(r_out), OW'(BLK));
      if (xstart != 0) check(r_out == BLK, "R9 row count with extra start", OW'(r_out), OW'(BLK));
      start = 1'b0;
      for (int i = 0; i < 4; i++) begin
         in_valid  = 1'b1;
         in_row    = make_row(2, 3, i);
         out_ready = 1'b1;
         #(CLK_T/4);
         check(!in_ready && !out_valid && !done, "R10 idle ignores input",
               OW'({in_ready, out_valid, done}), OW'(0));
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_row = '0;
      @(negedge clk);
      @(negedge clk);
      #(CLK_T/4);
      check(!in_ready && !out_valid && !done, "R11 reset state",
            OW'({in_ready, out_valid, done}), OW'(0));
      @(negedge clk);
      rst_n = 1'b1;
      #(CLK_T/4);
      check(!in_ready && !out_valid && !done, "R11 after reset release",
            OW'({in_ready, out_valid, done}), OW'(0));
      @(negedge clk);
      for (int n = 0; n < NVEC; n++) begin
         run_block(TBL[n][0], TBL[n][1], TBL[n][2], TBL[n][3]);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_T * 150000);
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule